// File: doc/BRIEF.md
# Coding-Unit Pixel Position Generator

This block produces the top-left pixel coordinates (x, y) of the representative sub-blocks inside a coding unit, measured from the coding unit's own origin. Each axis is built from a one-bit representative selector and a modulo-4 counter that picks the 16×16 region. The coordinate is the region index times 16, plus 12 when the selector is set and plus 0 when it is clear. In a single 16×16 region the four representatives therefore sit at (0,0), (12,0), (0,12) and (12,12).

An external controller sequences the walk. For each axis it pulses a step for the selector, a step for the region counter, and a clear for the region counter. The block compares each region counter with the last legal index for the selected coding-unit size (16, 32 or 64 pixels). It reports the result as a per-axis flag, which the controller uses to decide between advancing and wrapping. The selector on each axis is a two-state machine with states REP_NEAR (offset 0) and REP_FAR (offset 12). A selector step moves REP_NEAR to REP_FAR and REP_FAR back to REP_NEAR. Without a step the state stays where it is, and reset forces REP_NEAR.

Top module: `cu_pos_gen`

## Requirements
- R1: An asynchronous active-high reset clears both selectors to REP_NEAR and both region counters to 0, so `pos_x` and `pos_y` read 0 while reset is high and right after it is released.
- R2: A pulse on an axis's selector step flips that axis's selector at the next rising clock edge, so that axis's coordinate gains or loses 12 (bits [3:0] change between 0 and 12).
- R3: A region step on an axis, with no clear, raises that axis's region index (coordinate bits [5:4]) by one at the next edge, and it wraps from 3 to 0.
- R4: A region clear forces that axis's region index to 0 at the next edge, and it overrides a region step given in the same cycle.
- R5: Each coordinate is 6-bit unsigned and equals index×16 + (12 if REP_FAR else 0). Bits [1:0] are always 0, and bits [3:2] are either both 0 or both 1.
- R6: `size_sel` encoding: 0 = 16×16, 1 = 32×32, 2 = 64×64, and 3 is treated as 64×64. The per-axis last flag is high exactly when that axis's index equals 0, 1 or 3 respectively, and it follows `size_sel` in the same cycle.
- R7: The two axes are independent. Controls of one axis leave the other axis's coordinate and flag unchanged.
- R8: With size 16, three selector steps on x and one on y from reset give the sequence (12,0), (0,12), (12,12) after (0,0).
- R9: When no step and no clear is given, an axis holds its coordinate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| size_sel | input | 2 | Coding-unit size code (0:16, 1:32, 2/3:64) |
| rep_step_x | input | 1 | Flip the x representative selector |
| rep_step_y | input | 1 | Flip the y representative selector |
| blk_step_x | input | 1 | Advance the x region counter |
| blk_step_y | input | 1 | Advance the y region counter |
| blk_clr_x | input | 1 | Clear the x region counter |
| blk_clr_y | input | 1 | Clear the y region counter |
| pos_x | output | 6 | x coordinate of the current representative |
| pos_y | output | 6 | y coordinate of the current representative |
| last_x | output | 1 | x region index is the last for the size |
| last_y | output | 1 | y region index is the last for the size |

## Verification
The assertions check on every cycle that each coordinate stays on the legal 0/12 offset grid, that each selector step toggles the offset and its absence holds it, that the region index increments with wrap, clears with priority and otherwise holds, and that the last flag matches the index for the selected size. Reset clearing is checked away from the clock edge as well. Only the bench's scenarios show the complete 16×16 representative sequence, the behaviour of size code 3, an asynchronous reset asserted in mid-walk, and the independence of the two axes under mixed stimulus, since these depend on a particular order of controls.

// File: rtl/cu_pos_pkg.sv
package cu_pos_pkg;
    localparam int COORD_W   = 6;
    localparam int BLK_COUNT = 4;
    localparam int BLK_W     = $clog2(BLK_COUNT);
    localparam int BLK_SPAN  = 16;
    localparam int SPAN_SH   = $clog2(BLK_SPAN);
    localparam int REP_OFS   = 12;

    typedef enum logic [1:0] {
        CU_16  = 2'd0,
        CU_32  = 2'd1,
        CU_64  = 2'd2,
        CU_64B = 2'd3
    } cu_size_t;

    typedef enum logic {
        REP_NEAR = 1'b0,
        REP_FAR  = 1'b1
    } rep_state_t;
endpackage

// File: rtl/cu_rep_toggle.sv
module cu_rep_toggle
    import cu_pos_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic far_sel
);
    rep_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= REP_NEAR;
        else     state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        far_sel = 1'b0;
        unique case (state_q)
            REP_NEAR: begin
                far_sel = 1'b0;
                if (step) state_d = REP_FAR;
            end
            REP_FAR: begin
                far_sel = 1'b1;
                if (step) state_d = REP_NEAR;
            end
        endcase
    end
endmodule

// File: rtl/cu_blk_counter.sv
module cu_blk_counter
    import cu_pos_pkg::*;
#(
    parameter int COUNT = BLK_COUNT,
    parameter int W     = BLK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clr,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] IDX_MAX = W'(COUNT - 1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)            idx <= '0;
        else if (clr)       idx <= '0;
        else if (step) begin
            if (idx == IDX_MAX) idx <= '0;
            else                idx <= idx + W'(1);
        end
    end
endmodule

// File: rtl/cu_last_decode.sv
module cu_last_decode
    import cu_pos_pkg::*;
#(
    parameter int W = BLK_W
) (
    input  cu_size_t     size_sel,
    input  logic [W-1:0] idx,
    output logic         last
);
    logic [W-1:0] idx_lim;

    always_comb begin
        unique case (size_sel)
            CU_16:   idx_lim = W'(0);
            CU_32:   idx_lim = W'(1);
            CU_64,
            CU_64B:  idx_lim = W'(BLK_COUNT - 1);
        endcase
        last = (idx == idx_lim);
    end
endmodule

// File: rtl/cu_pos_axis.sv
module cu_pos_axis
    import cu_pos_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cu_size_t           size_sel,
    input  logic               rep_step,
    input  logic               blk_step,
    input  logic               blk_clr,
    output logic [COORD_W-1:0] pos,
    output logic               last
);
    logic             far_sel;
    logic [BLK_W-1:0] idx;

    cu_rep_toggle u_rep (
        .clk     (clk),
        .rst     (rst),
        .step    (rep_step),
        .far_sel (far_sel)
    );

    cu_blk_counter #(.COUNT(BLK_COUNT), .W(BLK_W)) u_blk (
        .clk  (clk),
        .rst  (rst),
        .step (blk_step),
        .clr  (blk_clr),
        .idx  (idx)
    );

    cu_last_decode #(.W(BLK_W)) u_last (
        .size_sel (size_sel),
        .idx      (idx),
        .last     (last)
    );

    always_comb begin
        pos = COORD_W'(idx) << SPAN_SH;
        if (far_sel) pos = pos + COORD_W'(REP_OFS);
    end
endmodule

// File: rtl/cu_pos_gen.sv
module cu_pos_gen
    import cu_pos_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         size_sel,
    input  logic               rep_step_x,
    input  logic               rep_step_y,
    input  logic               blk_step_x,
    input  logic               blk_step_y,
    input  logic               blk_clr_x,
    input  logic               blk_clr_y,
    output logic [COORD_W-1:0] pos_x,
    output logic [COORD_W-1:0] pos_y,
    output logic               last_x,
    output logic               last_y
);
    localparam int AXES = 2;

    cu_size_t           size_e;
    logic               rep_step [AXES];
    logic               blk_step [AXES];
    logic               blk_clr  [AXES];
    logic [COORD_W-1:0] pos      [AXES];
    logic               last     [AXES];

    assign size_e      = cu_size_t'(size_sel);
    assign rep_step[0] = rep_step_x;
    assign rep_step[1] = rep_step_y;
    assign blk_step[0] = blk_step_x;
    assign blk_step[1] = blk_step_y;
    assign blk_clr[0]  = blk_clr_x;
    assign blk_clr[1]  = blk_clr_y;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        cu_pos_axis u_axis (
            .clk      (clk),
            .rst      (rst),
            .size_sel (size_e),
            .rep_step (rep_step[a]),
            .blk_step (blk_step[a]),
            .blk_clr  (blk_clr[a]),
            .pos      (pos[a]),
            .last     (last[a])
        );
    end

    assign pos_x  = pos[0];
    assign pos_y  = pos[1];
    assign last_x = last[0];
    assign last_y = last[1];
endmodule

// File: rtl/cu_pos_axis_chk.sv
module cu_pos_axis_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] size_sel,
    input logic       rep_step,
    input logic       blk_step,
    input logic       blk_clr,
    input logic [5:0] pos,
    input logic       last
);
    always @(negedge clk) begin
        if (rst) begin
            assert_reset_clear_R1: assert (pos == 6'd0)
                else $error("R1 coordinate not cleared in reset");
        end
    end

    assert_rep_flip_R2: assert property (@(posedge clk) disable iff (rst)
        rep_step |=> (pos[3:0] != $past(pos[3:0])));

    assert_blk_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (blk_step && !blk_clr) |=> (pos[5:4] == 2'($past(pos[5:4]) + 2'd1)));

    assert_blk_clr_R4: assert property (@(posedge clk) disable iff (rst)
        blk_clr |=> (pos[5:4] == 2'd0));

    assert_grid_R5: assert property (@(posedge clk) disable iff (rst)
        (pos[1:0] == 2'b00) && (pos[3] == pos[2]));

    assert_last16_R6: assert property (@(posedge clk) disable iff (rst)
        (size_sel == 2'd0) |-> (last == (pos[5:4] == 2'd0)));

    assert_last32_R6: assert property (@(posedge clk) disable iff (rst)
        (size_sel == 2'd1) |-> (last == (pos[5:4] == 2'd1)));

    assert_last64_R6: assert property (@(posedge clk) disable iff (rst)
        (size_sel[1]) |-> (last == (pos[5:4] == 2'd3)));

    assert_rep_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rep_step |=> $stable(pos[3:0]));

    assert_blk_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!blk_step && !blk_clr) |=> $stable(pos[5:4]));
endmodule

bind cu_pos_gen cu_pos_axis_chk u_chk_x (
    .clk      (clk),
    .rst      (rst),
    .size_sel (size_sel),
    .rep_step (rep_step_x),
    .blk_step (blk_step_x),
    .blk_clr  (blk_clr_x),
    .pos      (pos_x),
    .last     (last_x)
);

bind cu_pos_gen cu_pos_axis_chk u_chk_y (
    .clk      (clk),
    .rst      (rst),
    .size_sel (size_sel),
    .rep_step (rep_step_y),
    .blk_step (blk_step_y),
    .blk_clr  (blk_clr_y),
    .pos      (pos_y),
    .last     (last_y)
);

// File: tb/cu_pos_gen_tb.sv
`timescale 1ns/1ps
module cu_pos_gen_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] size_sel;
    logic       rep_step_x, rep_step_y, blk_step_x, blk_step_y, blk_clr_x, blk_clr_y;
    logic [5:0] pos_x, pos_y;
    logic       last_x, last_y;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cu_pos_gen u_dut (
        .clk(clk), .rst(rst), .size_sel(size_sel),
        .rep_step_x(rep_step_x), .rep_step_y(rep_step_y),
        .blk_step_x(blk_step_x), .blk_step_y(blk_step_y),
        .blk_clr_x(blk_clr_x), .blk_clr_y(blk_clr_y),
        .pos_x(pos_x), .pos_y(pos_y), .last_x(last_x), .last_y(last_y)
    );

    // {size, rx, ry, bx, by, cx, cy, exp_x, exp_y, exp_lx, exp_ly}
    localparam int NVEC = 14;
    localparam logic [21:0] VEC [NVEC] = '{
        {2'd0, 6'b100000, 6'd12, 6'd0,  1'b1, 1'b1}, // R8 R7
        {2'd0, 6'b110000, 6'd0,  6'd12, 1'b1, 1'b1}, // R8 R2
        {2'd0, 6'b100000, 6'd12, 6'd12, 1'b1, 1'b1}, // R8
        {2'd0, 6'b000000, 6'd12, 6'd12, 1'b1, 1'b1}, // R9
        {2'd2, 6'b001000, 6'd28, 6'd12, 1'b0, 1'b0}, // R3 R5 R6
        {2'd2, 6'b001100, 6'd44, 6'd28, 1'b0, 1'b0}, // R3
        {2'd2, 6'b001000, 6'd60, 6'd28, 1'b1, 1'b0}, // R3 R6
        {2'd2, 6'b101000, 6'd0,  6'd28, 1'b0, 1'b0}, // R3 wrap, R2
        {2'd1, 6'b000100, 6'd0,  6'd44, 1'b0, 1'b0}, // R3 R7
        {2'd1, 6'b000101, 6'd0,  6'd12, 1'b0, 1'b0}, // R4 priority
        {2'd1, 6'b001100, 6'd16, 6'd28, 1'b1, 1'b1}, // R6 size 32
        {2'd3, 6'b000000, 6'd16, 6'd28, 1'b0, 1'b0}, // R6 code 3, R9
        {2'd1, 6'b000010, 6'd0,  6'd28, 1'b0, 1'b1}, // R4 R7
        {2'd0, 6'b010000, 6'd0,  6'd16, 1'b1, 1'b0}  // R2 R6
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] sz, input logic [5:0] c);
        size_sel   = sz;
        rep_step_x = c[5]; rep_step_y = c[4];
        blk_step_x = c[3]; blk_step_y = c[2];
        blk_clr_x  = c[1]; blk_clr_y  = c[0];
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(2'd0, 6'b000000);
        @(negedge clk);
        drive(2'd0, 6'b111100); // steps while reset held must do nothing
        @(negedge clk);
        check("R1 pos_x in reset", pos_x, 0);
        check("R1 pos_y in reset", pos_y, 0);
        drive(2'd0, 6'b000000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pos_x after release", pos_x, 0);
        check("R1 pos_y after release", pos_y, 0);
        check("R6 last_x at reset size16", last_x, 1);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][21:20], VEC[i][19:14]);
            @(negedge clk);
            check($sformatf("R5 row %0d pos_x", i), pos_x, VEC[i][13:8]);
            check($sformatf("R5 row %0d pos_y", i), pos_y, VEC[i][7:2]);
            check($sformatf("R6 row %0d last_x", i), last_x, VEC[i][1]);
            check($sformatf("R6 row %0d last_y", i), last_y, VEC[i][0]);
        end

        // R6: flag follows size in the same cycle (x idx 0, y idx 1)
        drive(2'd1, 6'b000000);
        #1;
        check("R6 comb last_y size32", last_y, 1);
        check("R6 comb last_x size32", last_x, 0);

        // R1: asynchronous reset in mid-walk, between edges
        drive(2'd2, 6'b111100);
        @(negedge clk);
        #1 rst = 1'b1;
        #1;
        check("R1 async pos_x", pos_x, 0);
        check("R1 async pos_y", pos_y, 0);
        drive(2'd2, 6'b000000);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 hold after reset x", pos_x, 0);
        check("R6 last_x size64 idx0", last_x, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule